// File: doc/BRIEF.md
# GPIO Configuration Register Bank

This block is the register file of a general-purpose I/O controller serving 94 pins. A simple 32-bit request/acknowledge bus with byte addresses reaches two kinds of storage. Bitmapped words pack 32 pins each, so pin n lives in word n/32 at bit n%32. A strided pair of configuration words belongs to each pin. From this storage the block drives each pin's output level, output enable, mode (native or GPIO), input-sense gating, weak-pull code and interrupt trigger fields. It also samples pad levels back into a readable bit.

A small bus state machine sequences every access. In `ST_IDLE` a request is captured. It then moves to `ST_WRITE` (transition IDLE_TO_WRITE, when the write flag is set) or to `ST_READ` (transition IDLE_TO_READ, when it is clear). Either state acknowledges for one cycle and returns to idle (transitions WRITE_TO_IDLE and READ_TO_IDLE). The pin ownership map comes from a strap vector and cannot be written from the bus. Interrupt detection lives in a separate block. This bank only holds the enable words and the sticky status words, which that block sets through `irq_hit`.

Top module: `gpio_regbank`

## Requirements
- R1: Synchronous reset (`rst_n` low) sets every pin to input direction, output level 0, input sensing disabled, pull code 0, trigger and invert 0, and use-select equal to `use_strap[n]`. It clears all interrupt enables, all status bits and the global control word.
- R2: A request seen in idle is acknowledged exactly one cycle after the clock edge that captured it, and `bus_ack` stays high for one cycle only.
- R3: The ownership words at byte offsets 0x00, 0x04 and 0x08 read `own_strap` (pin n at word n/32, bit n%32). Bus writes to them have no effect.
- R4: Per-pin word A sits at 0x100 + 8·n. Bit 31 is output level, bit 30 is the read-only sampled input, bit 4 is trigger select, bit 3 is interrupt invert, bit 2 is direction (1 input, 0 output) and bit 0 is use-select (1 GPIO, 0 native). All other bits read 0.
- R5: Per-pin word B sits at 0x104 + 8·n. Bit 2 disables input sensing and bits 1:0 hold the pull code. All other bits read 0.
- R6: With sensing enabled, bit 30 of word A and `pin_sensed[n]` follow `pad_in[n]` one clock later. With sensing disabled, both are 0.
- R7: `pad_oe[n]` is 1 only when use-select is 1 and direction is 0. `pad_out[n]` is the output-level bit.
- R8: The interrupt enable words at 0x90, 0x94 and 0x98 are read/write, and `irq_enable` mirrors them.
- R9: Status words at 0x80, 0x84 and 0x88 set a bit on `irq_hit[n]` and clear it when a 1 is written to it. A hit in the same cycle as the clear wins, and writing 0 leaves the bit unchanged.
- R10: Reads of unmapped offsets return 0, and so do addresses whose two low bits are not 00. Writes to them change nothing. Bit positions for pins 94 and 95 read 0.
- R11: The global control word at 0x7C is read/write and drives `glb_ctrl`.
- R12: `pin_pull`, `trig_level`, `trig_invert` and `pin_gpio_mode` reflect the stored fields of each pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request, sampled in idle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | One-cycle acknowledge |
| bus_rdata | output | 32 | Read data, valid while acknowledge is high on a read |
| own_strap | input | 94 | Ownership map, 0 marks a pin reserved for firmware |
| use_strap | input | 94 | Reset value of each pin's use-select |
| pad_in | input | 94 | Pad input levels |
| pad_out | output | 94 | Pad output levels |
| pad_oe | output | 94 | Pad output enables |
| pin_gpio_mode | output | 94 | Use-select per pin |
| pin_pull | output | 188 | Pull code, pin n at bits 2n+1:2n |
| pin_sensed | output | 94 | Gated input level toward interrupt logic |
| trig_level | output | 94 | Trigger select per pin |
| trig_invert | output | 94 | Invert per pin |
| irq_hit | input | 94 | Status set pulses from the detector |
| irq_enable | output | 94 | Interrupt enables |
| irq_status | output | 94 | Sticky interrupt status |
| glb_ctrl | output | 32 | Global control word |

## Verification
A decode fault that selects the wrong pin or word appears on the pin outputs as soon as the write completes. It appears on `bus_rdata` at the next read of either the intended or the hit location. A stuck state machine shows at once as a missing or doubled acknowledge. Sense-gating faults show within one clock of a `pad_in` change, on both `pin_sensed` and bit 30 of word A. Status faults show one clock after an `irq_hit` pulse, or after a write-one-to-clear that races a hit.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } bus_state_e;

    typedef struct packed {
        logic       out_lvl;
        logic       trig_lvl;
        logic       inv;
        logic       dir_in;
        logic       use_gpio;
        logic       sense_off;
        logic [1:0] pull;
    } pin_cfg_t;

    // word A field positions
    localparam int unsigned A_OUT  = 31;
    localparam int unsigned A_IN   = 30;
    localparam int unsigned A_TRIG = 4;
    localparam int unsigned A_INV  = 3;
    localparam int unsigned A_DIR  = 2;
    localparam int unsigned A_USE  = 0;
    // word B field positions
    localparam int unsigned B_SENSE = 2;

    // byte offsets
    localparam int unsigned OFS_OWN  = 'h000;
    localparam int unsigned OFS_GLB  = 'h07C;
    localparam int unsigned OFS_STAT = 'h080;
    localparam int unsigned OFS_EN   = 'h090;
    localparam int unsigned OFS_CFG  = 'h100;

endpackage

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg
    import gpio_bank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        strap_use,
    input  logic        wr_a,
    input  logic        wr_b,
    input  logic [31:0] wdata,
    input  logic        pad_in,
    output pin_cfg_t    cfg,
    output logic        in_lvl
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.out_lvl   <= 1'b0;
            cfg.trig_lvl  <= 1'b0;
            cfg.inv       <= 1'b0;
            cfg.dir_in    <= 1'b1;
            cfg.use_gpio  <= strap_use;
            cfg.sense_off <= 1'b1;
            cfg.pull      <= 2'b00;
            in_lvl        <= 1'b0;
        end else begin
            if (wr_a) begin
                cfg.out_lvl  <= wdata[A_OUT];
                cfg.trig_lvl <= wdata[A_TRIG];
                cfg.inv      <= wdata[A_INV];
                cfg.dir_in   <= wdata[A_DIR];
                cfg.use_gpio <= wdata[A_USE];
            end
            if (wr_b) begin
                cfg.sense_off <= wdata[B_SENSE];
                cfg.pull      <= wdata[1:0];
            end
            in_lvl <= pad_in & ~cfg.sense_off;
        end
    end

    AST_SENSE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg.sense_off)) |-> !in_lvl); // R6
    AST_SENSE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg.sense_off)) |-> (in_lvl == $past(pad_in))); // R6

endmodule

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_bank_pkg::*;
#(
    parameter int unsigned AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    output logic          ack,
    output logic          wr_stb,
    output logic          rd_act,
    output logic [AW-1:0] hold_addr,
    output logic [31:0]   hold_wdata
);

    bus_state_e state;

    // state register with transitions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            hold_addr  <= '0;
            hold_wdata <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req) begin
                        hold_addr  <= addr;
                        hold_wdata <= wdata;
                        state      <= we ? ST_WRITE : ST_READ;
                    end
                end
                ST_WRITE: state <= ST_IDLE;
                ST_READ:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        ack    = 1'b0;
        wr_stb = 1'b0;
        rd_act = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_WRITE: begin ack = 1'b1; wr_stb = 1'b1; end
            ST_READ:  begin ack = 1'b1; rd_act = 1'b1; end
            default:  ;
        endcase
    end

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R2
    AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack && state == ST_IDLE) |=> ack); // R2

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPIN = 94,  // must stay at or below 128
    parameter int unsigned AW   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_ack,
    output logic [31:0]       bus_rdata,
    input  logic [NPIN-1:0]   own_strap,
    input  logic [NPIN-1:0]   use_strap,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic [NPIN-1:0]   pin_gpio_mode,
    output logic [2*NPIN-1:0] pin_pull,
    output logic [NPIN-1:0]   pin_sensed,
    output logic [NPIN-1:0]   trig_level,
    output logic [NPIN-1:0]   trig_invert,
    input  logic [NPIN-1:0]   irq_hit,
    output logic [NPIN-1:0]   irq_enable,
    output logic [NPIN-1:0]   irq_status,
    output logic [31:0]       glb_ctrl
);

    localparam int unsigned NWORD = (NPIN + 31) / 32;
    localparam int unsigned PW    = $clog2(NPIN);
    localparam logic [AW-1:0] CFG_LO = AW'(OFS_CFG);
    localparam logic [AW-1:0] CFG_HI = AW'(OFS_CFG + 8 * NPIN);

    logic          wr_stb, rd_act;
    logic [AW-1:0] a;
    logic [31:0]   wd;

    gpio_bus_fsm #(.AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req(bus_req), .we(bus_we),
        .addr(bus_addr), .wdata(bus_wdata), .ack(bus_ack),
        .wr_stb(wr_stb), .rd_act(rd_act), .hold_addr(a), .hold_wdata(wd)
    );

    // address decode
    logic          aligned, is_own, is_stat, is_en, is_glb, is_cfg, sel_b;
    logic [1:0]    widx;
    logic [AW-1:0] cfg_off;
    logic [PW-1:0] pidx;

    always_comb begin
        aligned = (a[1:0] == 2'b00);
        widx    = a[3:2];
        is_own  = aligned && (a < AW'(OFS_OWN + 4 * NWORD));
        is_stat = aligned && (a >= AW'(OFS_STAT)) && (a < AW'(OFS_STAT + 4 * NWORD));
        is_en   = aligned && (a >= AW'(OFS_EN)) && (a < AW'(OFS_EN + 4 * NWORD));
        is_glb  = aligned && (a == AW'(OFS_GLB));
        is_cfg  = aligned && (a >= CFG_LO) && (a < CFG_HI);
        cfg_off = a - CFG_LO;
        sel_b   = cfg_off[2];
        pidx    = cfg_off[PW+2:3];
    end

    pin_cfg_t cfg_arr [NPIN];
    logic [NPIN-1:0] in_arr;
    logic [NPIN-1:0] en_q, st_q;
    logic [31:0]     own_w [NWORD];
    logic [31:0]     en_w  [NWORD];
    logic [31:0]     st_w  [NWORD];

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        localparam int unsigned WI = i / 32;
        localparam int unsigned BI = i % 32;
        logic hit_a, hit_b, en_wr, st_wr;

        assign hit_a = wr_stb && is_cfg && (pidx == PW'(i)) && !sel_b;
        assign hit_b = wr_stb && is_cfg && (pidx == PW'(i)) &&  sel_b;
        assign en_wr = wr_stb && is_en   && (widx == 2'(WI));
        assign st_wr = wr_stb && is_stat && (widx == 2'(WI));

        gpio_pin_cfg u_cfg (
            .clk(clk), .rst_n(rst_n), .strap_use(use_strap[i]),
            .wr_a(hit_a), .wr_b(hit_b), .wdata(wd), .pad_in(pad_in[i]),
            .cfg(cfg_arr[i]), .in_lvl(in_arr[i])
        );

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[i] <= 1'b0;
                st_q[i] <= 1'b0;
            end else begin
                if (en_wr) en_q[i] <= wd[BI];
                st_q[i] <= irq_hit[i] | (st_q[i] & ~(st_wr & wd[BI]));
            end
        end

        assign pad_out[i]         = cfg_arr[i].out_lvl;
        assign pad_oe[i]          = cfg_arr[i].use_gpio & ~cfg_arr[i].dir_in;
        assign pin_gpio_mode[i]   = cfg_arr[i].use_gpio;
        assign pin_pull[2*i +: 2] = cfg_arr[i].pull;
        assign trig_level[i]      = cfg_arr[i].trig_lvl;
        assign trig_invert[i]     = cfg_arr[i].inv;
        assign pin_sensed[i]      = in_arr[i];
    end

    // bitmapped word views, bits past the last pin read 0
    for (genvar w = 0; w < NWORD; w++) begin : g_word
        for (genvar b = 0; b < 32; b++) begin : g_bit
            if (32 * w + b < NPIN) begin : g_real
                assign own_w[w][b] = own_strap[32*w+b];
                assign en_w[w][b]  = en_q[32*w+b];
                assign st_w[w][b]  = st_q[32*w+b];
            end else begin : g_pad
                assign own_w[w][b] = 1'b0;
                assign en_w[w][b]  = 1'b0;
                assign st_w[w][b]  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)               glb_ctrl <= '0;
        else if (wr_stb && is_glb) glb_ctrl <= wd;
    end

    // read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (rd_act) begin
            for (int w = 0; w < NWORD; w++) begin
                if (widx == 2'(w)) begin
                    if (is_own)  bus_rdata = own_w[w];
                    if (is_en)   bus_rdata = en_w[w];
                    if (is_stat) bus_rdata = st_w[w];
                end
            end
            if (is_glb) bus_rdata = glb_ctrl;
            if (is_cfg) begin
                if (sel_b) begin
                    bus_rdata[B_SENSE] = cfg_arr[pidx].sense_off;
                    bus_rdata[1:0]     = cfg_arr[pidx].pull;
                end else begin
                    bus_rdata[A_OUT]  = cfg_arr[pidx].out_lvl;
                    bus_rdata[A_IN]   = in_arr[pidx];
                    bus_rdata[A_TRIG] = cfg_arr[pidx].trig_lvl;
                    bus_rdata[A_INV]  = cfg_arr[pidx].inv;
                    bus_rdata[A_DIR]  = cfg_arr[pidx].dir_in;
                    bus_rdata[A_USE]  = cfg_arr[pidx].use_gpio;
                end
            end
        end
    end

    assign irq_enable = en_q;
    assign irq_status = st_q;

    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_stb)) |-> ((irq_status & $past(irq_status)) == $past(irq_status))); // R9
    AST_HIT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(irq_hit) & ~irq_status) == '0)); // R9
    AST_EN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_stb)) |-> $stable(irq_enable)); // R8
    AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_stb)) |-> $stable(pad_oe)); // R7

endmodule

// File: tb/test_gpio_regbank.sv
`timescale 1ns/1ps
module test_gpio_regbank;

    localparam int NPIN = 94;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              bus_req, bus_we;
    logic [11:0]       bus_addr;
    logic [31:0]       bus_wdata, bus_rdata;
    logic              bus_ack;
    logic [NPIN-1:0]   own_strap, use_strap, pad_in, irq_hit;
    logic [NPIN-1:0]   pad_out, pad_oe, pin_gpio_mode, pin_sensed;
    logic [NPIN-1:0]   trig_level, trig_invert, irq_enable, irq_status;
    logic [2*NPIN-1:0] pin_pull;
    logic [31:0]       glb_ctrl;

    always #10 clk = ~clk;  // 50 MHz

    gpio_regbank i_gpio_regbank (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .own_strap(own_strap), .use_strap(use_strap),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pin_gpio_mode(pin_gpio_mode), .pin_pull(pin_pull),
        .pin_sensed(pin_sensed), .trig_level(trig_level),
        .trig_invert(trig_invert), .irq_hit(irq_hit),
        .irq_enable(irq_enable), .irq_status(irq_status), .glb_ctrl(glb_ctrl)
    );

    typedef struct {
        bit          chk;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int n_cmp  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops one item per acknowledge
    always @(negedge clk) begin
        if (rst_n && bus_ack) begin
            if (sb_q.size() == 0) begin
                n_cmp++; n_fail++;
                $display("FAIL R2: actual unexpected ack expected none");
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                if (it.chk) check(bus_rdata, it.exp, it.tag);
            end
        end
    end

    // driver
    task automatic xfer(input bit we, input logic [11:0] a, input logic [31:0] wd,
                        input bit chk, input logic [31:0] exp, input string tag);
        sb_q.push_back('{chk, exp, tag});
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0;
        check({31'd0, bus_ack}, 32'd1, "R2 ack one cycle after capture");
        @(negedge clk);
        check({31'd0, bus_ack}, 32'd0, "R2 ack lasts one cycle");
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] wd);
        xfer(1'b1, a, wd, 1'b0, '0, "");
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        xfer(1'b0, a, '0, 1'b1, exp, tag);
    endtask

    function automatic logic [31:0] own_word(input int w);
        logic [31:0] v = '0;
        for (int b = 0; b < 32; b++) begin
            int idx = 32 * w + b;
            if (idx < NPIN) v[b] = (idx % 3) != 0;
        end
        return v;
    endfunction

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_cmp++; n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        pad_in = '0; irq_hit = '0;
        for (int i = 0; i < NPIN; i++) begin
            own_strap[i] = (i % 3) != 0;
            use_strap[i] = (i % 2) == 1;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(32'(pad_oe != 0), 0, "R1 pad_oe cleared");
        check(32'(irq_enable != 0), 0, "R1 enables cleared");
        check(32'(irq_status != 0), 0, "R1 status cleared");
        check(32'(pin_gpio_mode != use_strap), 0, "R1 use-select from strap");
        check(glb_ctrl, 0, "R1 global control cleared");
        rd(12'h128, 32'h0000_0005, "R1 word A pin 5 after reset");
        rd(12'h120, 32'h0000_0004, "R1 word A pin 4 after reset");
        rd(12'h12C, 32'h0000_0004, "R1 word B pin 5 after reset");

        // R3 ownership
        for (int w = 0; w < 3; w++) rd(12'(4 * w), own_word(w), "R3 ownership word");
        wr(12'h000, 32'h0000_0000);
        rd(12'h000, own_word(0), "R3 ownership write ignored");

        // R4 word A fields
        wr(12'h128, 32'hFFFF_FFFF);
        rd(12'h128, 32'h8000_001D, "R4 word A writable bits, bit30 read-only");

        // R7 output enable
        wr(12'h128, 32'h8000_0001);
        check({30'd0, pad_oe[5], pad_out[5]}, 32'd3, "R7 gpio output drives oe and level");
        wr(12'h130, 32'h0000_0000);
        check({31'd0, pad_oe[6]}, 32'd0, "R7 native mode gives no oe");

        // R12 trigger fields
        wr(12'h138, 32'h0000_0018);
        check({30'd0, trig_level[7], trig_invert[7]}, 32'd3, "R12 trigger and invert outputs");

        // R5 word B, R12 pull
        wr(12'h3EC, 32'h0000_0003);
        rd(12'h3EC, 32'h0000_0003, "R5 word B pin 93");
        check({30'd0, pin_pull[187:186]}, 32'd3, "R12 pull code output");

        // R6 input sampling
        pad_in[93] = 1'b1; pad_in[5] = 1'b1;
        @(negedge clk);
        check({31'd0, pin_sensed[93]}, 32'd1, "R6 sensed follows pad");
        check({31'd0, pin_sensed[5]}, 32'd0, "R6 sensing disabled gives 0");
        rd(12'h3E8, 32'h4000_0005, "R6 input bit visible in word A");
        rd(12'h128, 32'h8000_0001, "R6 input bit 0 when sensing off");

        // R8 enables
        wr(12'h094, 32'hA5A5_A5A5);
        check(irq_enable[63:32], 32'hA5A5_A5A5, "R8 enable port mirrors word 1");
        rd(12'h094, 32'hA5A5_A5A5, "R8 enable readback");
        wr(12'h098, 32'hFFFF_FFFF);
        rd(12'h098, 32'h3FFF_FFFF, "R10 pins 94 and 95 read 0");
        check({2'b00, irq_enable[93:64]}, 32'h3FFF_FFFF, "R8 enable word 2 port");

        // R9 status
        irq_hit[40] = 1'b1;
        @(negedge clk);
        irq_hit[40] = 1'b0;
        check({31'd0, irq_status[40]}, 32'd1, "R9 hit sets status");
        wr(12'h084, 32'h0000_0000);
        rd(12'h084, 32'h0000_0100, "R9 writing 0 keeps status");
        irq_hit[40] = 1'b1;
        wr(12'h084, 32'h0000_0100);
        check({31'd0, irq_status[40]}, 32'd1, "R9 hit wins over clear");
        irq_hit[40] = 1'b0;
        wr(12'h084, 32'h0000_0100);
        check({31'd0, irq_status[40]}, 32'd0, "R9 write one clears");

        // R11 global control
        wr(12'h07C, 32'h1234_5678);
        rd(12'h07C, 32'h1234_5678, "R11 global control readback");
        check(glb_ctrl, 32'h1234_5678, "R11 global control port");

        // R10 unmapped
        wr(12'h040, 32'hFFFF_FFFF);
        rd(12'h040, 32'h0, "R10 unmapped read 0");
        wr(12'h3F0, 32'hFFFF_FFFF);
        rd(12'h3F0, 32'h0, "R10 past last pin read 0");
        wr(12'h12A, 32'h0000_0000);
        rd(12'h12A, 32'h0, "R10 unaligned read 0");
        rd(12'h128, 32'h8000_0001, "R10 unaligned write ignored");
        rd(12'h07C, 32'h1234_5678, "R10 unmapped writes leave control");

        repeat (2) @(negedge clk);
        check(32'(sb_q.size()), 0, "R2 every request acknowledged");
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule